// File: doc/BRIEF.md
# DMA Source-Chain Tag Sequencer

This block steers one source-side DMA channel through a linked list of 128-bit descriptors ("tags") held in memory. After software writes the channel control word with the start bit set, the sequencer fetches the tag at the current tag pointer. It decodes the transfer count, the tag type, the interrupt flag and the address field from the tag, and then hands blocks of quadwords to an external data mover. The tag type decides where each data block sits and where the next tag comes from. A two-slot return-address stack lets a chain call a sub-list and return from it.

The channel can also run in plain block mode, which moves one block of quadwords at the programmed memory address with no tags. The sequencer exposes its working registers (control word, memory address, tag address, count, return slots) as outputs. At the end of a chain it clears the start bit and raises a one-cycle done pulse. A failed tag read stops the channel and flags an error instead.

Top module: `dma_chain_seq`

## Requirements
- R1: With control bits 3:2 = 0 (block mode), a start moves one block of the programmed count at the programmed memory address. Afterwards the memory address has advanced by count×16 and the count reads 0.
- R2: A tag is decoded as follows: count in bits 15:0, type in bits 30:28, interrupt flag in bit 31, address field in bits 63:32. On each good fetch, control bits 31:16 take tag bits 31:16 and control bits 15:0 are kept.
- R3: Tag types: 0 moves data at the address field and ends the chain with the tag pointer unchanged. 1 moves data after the tag and then points past that data. 2 moves data after the tag and then points to the address field. 3 and 4 move data at the address field and then point to tag+16. 7 moves data after the tag and ends the chain with the tag pointer unchanged. "After the tag" means at tag address+16.
- R4: A type-5 (call) tag moves data after the tag and computes return address = tag+16+count×16. At depth 0 (control bits 5:4) the return address goes to slot 0 and depth becomes 1. At depth 1 it goes to slot 1 and depth becomes 2. In both cases the next tag pointer becomes the address field. At depth 2 the data still moves, the stack and tag pointer are left unchanged, and the chain ends.
- R5: A type-6 (return) tag moves data after the tag. At depth 2 the next tag comes from slot 1, slot 1 is cleared and depth becomes 1. At depth 1 the next tag comes from slot 0, slot 0 is cleared and depth becomes 0. At depth 0 or 3 the data still moves and the chain ends with the pointer unchanged.
- R6: With control bit 6 set, each fetched tag quadword is sent to the mover before its data. It is marked as a tag move, uses the tag's own address and a count of 1, and carries the fetched 128 bits.
- R7: With control bit 7 set, a tag whose interrupt flag is set ends the chain after its data moves. With bit 7 clear, the flag has no effect.
- R8: At the end of a transfer, control bit 8 (start) is cleared and done_irq_o pulses for exactly one cycle.
- R9: An error response to a tag read sets bus_err_o, clears the start bit, moves no data and raises no done pulse. The next configuration write clears bus_err_o.
- R10: A start with control bits 3:2 = 2 or 3 is ignored: no tag read, no move and no done pulse.
- R11: In chain mode, a start with a nonzero programmed count moves that block and ends without fetching a tag.
- R12: A tag with count 0 issues no data move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe, accepted while idle |
| cfg_ctrl_i | input | 32 | Control word (mode 3:2, depth 5:4, tag send 6, tag irq enable 7, start 8) |
| cfg_madr_i | input | ADDR_W | Initial memory address |
| cfg_tadr_i | input | ADDR_W | Initial tag address |
| cfg_qwc_i | input | 16 | Initial quadword count |
| ctrl_o | output | 32 | Current control word |
| madr_o | output | ADDR_W | Current memory address |
| tadr_o | output | ADDR_W | Current tag address |
| qwc_o | output | 16 | Current quadword count |
| asr0_o | output | ADDR_W | Return slot 0 |
| asr1_o | output | ADDR_W | Return slot 1 |
| busy_o | output | 1 | Sequencer active |
| done_irq_o | output | 1 | One-cycle completion pulse |
| bus_err_o | output | 1 | Tag read error flag |
| tag_req_o | output | 1 | Tag read request, held until response |
| tag_addr_o | output | ADDR_W | Tag read address |
| tag_rvalid_i | input | 1 | Tag read response valid |
| tag_err_i | input | 1 | Tag read error, with response |
| tag_rdata_i | input | 128 | Tag quadword |
| mv_req_o | output | 1 | Move request, held until mv_done_i |
| mv_tag_o | output | 1 | Move is the tag quadword |
| mv_addr_o | output | ADDR_W | Move source address |
| mv_qwc_o | output | 16 | Move length in quadwords |
| mv_tag_data_o | output | 128 | Tag quadword for tag moves |
| mv_done_i | input | 1 | Move completion |

## Verification
Several chains are run against the sequencer. One is a plain count-then-end list, run with tag sending off and then on. Another nests two calls and then unwinds them with two returns. There are also single-tag chains that hit call overflow, return on an empty stack and return with an invalid depth, plus a chain that walks the reference and next types. The ordered list of mover requests separates correct data placement from wrong pointer arithmetic. The final tag pointer, depth bits and return slots separate a real push or pop from a skipped one. Running the same flagged tag with interrupt enable on and off tells the early stop apart from normal continuation. A failing tag read, an interleave start and a chain start with a residual count confirm that nothing moves, or that no tag is fetched, when it must not be.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int QWC_W   = 16;
  localparam int QW_W    = 128;
  localparam int CTRL_W  = 32;
  localparam int MODE_LO = 2;
  localparam int DEPTH_LO = 4;
  localparam int TTE_BIT = 6;
  localparam int TIE_BIT = 7;
  localparam int STR_BIT = 8;
  localparam logic [1:0] MODE_BLOCK = 2'd0;
  localparam logic [1:0] MODE_CHAIN = 2'd1;

  typedef enum logic [2:0] {
    TID_REFE = 3'd0, TID_CNT = 3'd1, TID_NEXT = 3'd2, TID_REF = 3'd3,
    TID_REFS = 3'd4, TID_CALL = 3'd5, TID_RET = 3'd6, TID_END = 3'd7
  } tag_id_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_TAGMV, S_DATA, S_POST
  } seq_state_e;
endpackage

// File: rtl/dma_tag_decode.sv
module dma_tag_decode
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [63:0]       tag_i,
  input  logic [ADDR_W-1:0] tadr_i,
  output logic [QWC_W-1:0]  qwc_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] madr_o,
  output logic [ADDR_W-1:0] tadr_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              push_o,
  output logic              pop_o,
  output logic              last_o
);
  tag_id_e           id;
  logic [ADDR_W-1:0] addr, follow, span;

  assign qwc_o  = tag_i[15:0];
  assign irq_o  = tag_i[31];
  assign id     = tag_id_e'(tag_i[30:28]);
  assign addr   = tag_i[32 +: ADDR_W];
  assign follow = tadr_i + ADDR_W'(16);
  assign span   = ADDR_W'({qwc_o, 4'b0000});
  assign ret_addr_o = follow + span;

  always_comb begin
    madr_o = follow;
    tadr_o = tadr_i;
    push_o = 1'b0;
    pop_o  = 1'b0;
    last_o = 1'b0;
    unique case (id)
      TID_REFE: begin madr_o = addr; last_o = 1'b1; end
      TID_CNT:  tadr_o = follow + span;
      TID_NEXT: tadr_o = addr;
      TID_REF, TID_REFS: begin madr_o = addr; tadr_o = follow; end
      TID_CALL: begin tadr_o = addr; push_o = 1'b1; end
      TID_RET:  pop_o = 1'b1;
      TID_END:  last_o = 1'b1;
      default:  last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dma_ret_stack.sv
module dma_ret_stack #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [1:0]        depth_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  output logic [1:0]        depth_o,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] asr0_o,
  output logic [ADDR_W-1:0] asr1_o
);
  logic [ADDR_W-1:0] slot0_q, slot1_q;

  always_comb begin
    depth_o    = depth_i;
    pop_addr_o = '0;
    fault_o    = 1'b0;
    if (push_i) begin
      unique case (depth_i)
        2'd0:    depth_o = 2'd1;
        2'd1:    depth_o = 2'd2;
        default: fault_o = 1'b1;
      endcase
    end else if (pop_i) begin
      unique case (depth_i)
        2'd2:    begin depth_o = 2'd1; pop_addr_o = slot1_q; end
        2'd1:    begin depth_o = 2'd0; pop_addr_o = slot0_q; end
        default: fault_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot0_q <= '0;
      slot1_q <= '0;
    end else if (push_i && !fault_o) begin
      if (depth_i == 2'd0) slot0_q <= ret_addr_i;
      else                 slot1_q <= ret_addr_i;
    end else if (pop_i && !fault_o) begin
      if (depth_i == 2'd2) slot1_q <= '0;
      else                 slot0_q <= '0;
    end
  end

  assign asr0_o = slot0_q;
  assign asr1_o = slot1_q;

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && depth_i == 2'd2 |=> $stable(asr0_o) && $stable(asr1_o));
  p_push_slot0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && depth_i == 2'd0 |=> asr0_o == $past(ret_addr_i));
  p_pop_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && depth_i == 2'd1 |=> asr0_o == '0);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_ctrl_i,
  input  logic [ADDR_W-1:0] cfg_madr_i,
  input  logic [ADDR_W-1:0] cfg_tadr_i,
  input  logic [15:0]       cfg_qwc_i,
  output logic [31:0]       ctrl_o,
  output logic [ADDR_W-1:0] madr_o,
  output logic [ADDR_W-1:0] tadr_o,
  output logic [15:0]       qwc_o,
  output logic [ADDR_W-1:0] asr0_o,
  output logic [ADDR_W-1:0] asr1_o,
  output logic              busy_o,
  output logic              done_irq_o,
  output logic              bus_err_o,
  output logic              tag_req_o,
  output logic [ADDR_W-1:0] tag_addr_o,
  input  logic              tag_rvalid_i,
  input  logic              tag_err_i,
  input  logic [127:0]      tag_rdata_i,
  output logic              mv_req_o,
  output logic              mv_tag_o,
  output logic [ADDR_W-1:0] mv_addr_o,
  output logic [15:0]       mv_qwc_o,
  output logic [127:0]      mv_tag_data_o,
  input  logic              mv_done_i
);
  seq_state_e        state_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ADDR_W-1:0] madr_q, tadr_q, tag_at_q;
  logic [QWC_W-1:0]  qwc_q;
  logic [QW_W-1:0]   tagbuf_q;
  logic              end_q, irq_q, err_q;

  logic [QWC_W-1:0]  dec_qwc;
  logic              dec_irq, dec_push, dec_pop, dec_last;
  logic [ADDR_W-1:0] dec_madr, dec_tadr, dec_ret;
  logic [1:0]        stk_depth;
  logic [ADDR_W-1:0] stk_pop_addr;
  logic              stk_fault, good_tag, stk_op;
  logic [1:0]        start_mode;

  assign good_tag   = state_q == S_FETCH && tag_rvalid_i && !tag_err_i;
  assign stk_op     = dec_push || dec_pop;
  assign start_mode = cfg_ctrl_i[MODE_LO +: 2];

  dma_tag_decode #(.ADDR_W(ADDR_W)) u_dec (
    .tag_i      (tag_rdata_i[63:0]),
    .tadr_i     (tadr_q),
    .qwc_o      (dec_qwc),
    .irq_o      (dec_irq),
    .madr_o     (dec_madr),
    .tadr_o     (dec_tadr),
    .ret_addr_o (dec_ret),
    .push_o     (dec_push),
    .pop_o      (dec_pop),
    .last_o     (dec_last)
  );

  dma_ret_stack #(.ADDR_W(ADDR_W)) u_stk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (good_tag && dec_push),
    .pop_i      (good_tag && dec_pop),
    .depth_i    (ctrl_q[DEPTH_LO +: 2]),
    .ret_addr_i (dec_ret),
    .depth_o    (stk_depth),
    .pop_addr_o (stk_pop_addr),
    .fault_o    (stk_fault),
    .asr0_o     (asr0_o),
    .asr1_o     (asr1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ctrl_q   <= '0;
      madr_q   <= '0;
      tadr_q   <= '0;
      tag_at_q <= '0;
      qwc_q    <= '0;
      tagbuf_q <= '0;
      end_q    <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cfg_we_i) begin
          ctrl_q <= cfg_ctrl_i;
          madr_q <= cfg_madr_i;
          tadr_q <= cfg_tadr_i;
          qwc_q  <= cfg_qwc_i;
          err_q  <= 1'b0;
          end_q  <= 1'b1;
          if (cfg_ctrl_i[STR_BIT]) begin
            if (start_mode == MODE_BLOCK) begin
              state_q <= (cfg_qwc_i != '0) ? S_DATA : S_POST;
            end else if (start_mode == MODE_CHAIN) begin
              if (cfg_qwc_i != '0) state_q <= S_DATA;   // residual block, no tag walk
              else begin
                end_q   <= 1'b0;
                state_q <= S_FETCH;
              end
            end
          end
        end
        S_FETCH: if (tag_rvalid_i) begin
          if (tag_err_i) begin
            err_q           <= 1'b1;
            ctrl_q[STR_BIT] <= 1'b0;
            state_q         <= S_IDLE;
          end else begin
            ctrl_q[31:16] <= tag_rdata_i[31:16];
            qwc_q         <= dec_qwc;
            madr_q        <= dec_madr;
            tagbuf_q      <= tag_rdata_i;
            tag_at_q      <= tadr_q;
            if (stk_op && !stk_fault) ctrl_q[DEPTH_LO +: 2] <= stk_depth;
            if (!(stk_op && stk_fault)) tadr_q <= dec_pop ? stk_pop_addr : dec_tadr;
            end_q <= dec_last || (stk_op && stk_fault) || (ctrl_q[TIE_BIT] && dec_irq);
            if (ctrl_q[TTE_BIT])      state_q <= S_TAGMV;
            else if (dec_qwc != '0)   state_q <= S_DATA;
            else                      state_q <= S_POST;
          end
        end
        S_TAGMV: if (mv_done_i) state_q <= (qwc_q != '0) ? S_DATA : S_POST;
        S_DATA: if (mv_done_i) begin
          madr_q  <= madr_q + ADDR_W'({qwc_q, 4'b0000});
          qwc_q   <= '0;
          state_q <= S_POST;
        end
        S_POST: if (end_q) begin
          ctrl_q[STR_BIT] <= 1'b0;
          irq_q           <= 1'b1;
          state_q         <= S_IDLE;
        end else begin
          state_q <= S_FETCH;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ctrl_o        = ctrl_q;
  assign madr_o        = madr_q;
  assign tadr_o        = tadr_q;
  assign qwc_o         = qwc_q;
  assign busy_o        = state_q != S_IDLE;
  assign done_irq_o    = irq_q;
  assign bus_err_o     = err_q;
  assign tag_req_o     = state_q == S_FETCH;
  assign tag_addr_o    = tadr_q;
  assign mv_req_o      = state_q == S_TAGMV || state_q == S_DATA;
  assign mv_tag_o      = state_q == S_TAGMV;
  assign mv_addr_o     = (state_q == S_TAGMV) ? tag_at_q : madr_q;
  assign mv_qwc_o      = (state_q == S_TAGMV) ? 16'd1 : qwc_q;
  assign mv_tag_data_o = tagbuf_q;

  p_done_clears_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> !ctrl_o[STR_BIT]);
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);
  p_no_empty_move_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_req_o && !mv_tag_o |-> mv_qwc_o != '0);
  p_err_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_err_o) |-> !busy_o && !ctrl_o[STR_BIT] && !done_irq_o);
  p_ctrl_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_tag |=> ctrl_o[31:16] == $past(tag_rdata_i[31:16]));
endmodule

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4ns clk = ~clk;

  logic          cfg_we = 0;
  logic [31:0]   cfg_ctrl = 0;
  logic [AW-1:0] cfg_madr = 0, cfg_tadr = 0;
  logic [15:0]   cfg_qwc = 0;
  logic [31:0]   ctrl;
  logic [AW-1:0] madr, tadr, asr0, asr1, tag_addr, mv_addr;
  logic [15:0]   qwc, mv_qwc;
  logic          busy, done_irq, bus_err, tag_req, mv_req, mv_tag;
  logic          tag_rvalid = 0, tag_err = 0, mv_done = 0;
  logic [127:0]  tag_rdata = 0, mv_tag_data;

  dma_chain_seq #(.ADDR_W(AW)) u_dma_chain_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ctrl_i(cfg_ctrl),
    .cfg_madr_i(cfg_madr), .cfg_tadr_i(cfg_tadr), .cfg_qwc_i(cfg_qwc),
    .ctrl_o(ctrl), .madr_o(madr), .tadr_o(tadr), .qwc_o(qwc),
    .asr0_o(asr0), .asr1_o(asr1), .busy_o(busy), .done_irq_o(done_irq),
    .bus_err_o(bus_err), .tag_req_o(tag_req), .tag_addr_o(tag_addr),
    .tag_rvalid_i(tag_rvalid), .tag_err_i(tag_err), .tag_rdata_i(tag_rdata),
    .mv_req_o(mv_req), .mv_tag_o(mv_tag), .mv_addr_o(mv_addr), .mv_qwc_o(mv_qwc),
    .mv_tag_data_o(mv_tag_data), .mv_done_i(mv_done));

  int n_chk = 0, n_bad = 0, irq_cnt = 0, treq_cnt = 0;
  logic [127:0]  mem [128];
  logic [AW-1:0] err_addr = 32'hFFFF_FFF0;
  logic [48:0]   exp_q [$];
  string         exp_r [$];

  function automatic logic [127:0] tagq(input logic irq, input logic [2:0] id,
                                        input logic [15:0] n, input logic [31:0] a);
    return {32'h1111_2222, 32'h3333_4444, a, irq, id, 12'h5A5, n};
  endfunction

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic expect_mv(input string r, input logic t, input logic [31:0] a, input logic [15:0] n);
    exp_q.push_back({t, a, n});
    exp_r.push_back(r);
  endtask

  always @(posedge clk) if (done_irq) irq_cnt++;

  // tag memory responder
  initial forever begin
    @(negedge clk);
    if (tag_req) begin
      logic [AW-1:0] a;
      a = tag_addr;
      treq_cnt++;
      @(negedge clk);
      tag_rdata  = mem[a[10:4]];
      tag_err    = (a == err_addr);
      tag_rvalid = 1;
      @(negedge clk);
      tag_rvalid = 0;
      tag_err    = 0;
    end
  end

  // mover model and scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (mv_req) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL unexpected move act=%h exp=none", {mv_tag, mv_addr, mv_qwc});
      end else begin
        logic [48:0] e;
        string r;
        e = exp_q.pop_front();
        r = exp_r.pop_front();
        check(r, {15'd0, mv_tag, mv_addr, mv_qwc}, {15'd0, e});
        if (mv_tag) check({r, " tag data"}, mv_tag_data[63:0], mem[mv_addr[10:4]][63:0]);
      end
      @(negedge clk); mv_done = 1;
      @(negedge clk); mv_done = 0;
    end
  end

  task automatic run(input logic [31:0] c, input logic [31:0] m, input logic [31:0] t, input logic [15:0] n);
    @(negedge clk);
    cfg_we = 1; cfg_ctrl = c; cfg_madr = m; cfg_tadr = t; cfg_qwc = n;
    @(negedge clk);
    cfg_we = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drained(input string r);
    check({r, " all moves seen"}, exp_q.size(), 0);
    exp_q.delete(); exp_r.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ic, tc;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[0]  = tagq(0, 3'd1, 16'd2, 32'h0);        // CNT
    mem[3]  = tagq(0, 3'd7, 16'd1, 32'h0);        // END at 0x30
    mem[64] = tagq(0, 3'd5, 16'd1, 32'h500);      // CALL at 0x400
    mem[80] = tagq(0, 3'd5, 16'd0, 32'h600);      // CALL at 0x500
    mem[96] = tagq(0, 3'd6, 16'd1, 32'h0);        // RET at 0x600
    mem[81] = tagq(0, 3'd6, 16'd0, 32'h0);        // RET at 0x510
    mem[66] = tagq(0, 3'd7, 16'd0, 32'h0);        // END at 0x420
    mem[48] = tagq(0, 3'd5, 16'd2, 32'h0);        // CALL at 0x300
    mem[52] = tagq(0, 3'd6, 16'd1, 32'h0);        // RET at 0x340
    mem[56] = tagq(1, 3'd1, 16'd1, 32'h0);        // CNT+irq at 0x380
    mem[58] = tagq(0, 3'd7, 16'd0, 32'h0);        // END at 0x3A0
    mem[60] = tagq(0, 3'd3, 16'd2, 32'h8000);     // REF at 0x3C0
    mem[61] = tagq(0, 3'd2, 16'd1, 32'h3F0);      // NEXT at 0x3D0
    mem[63] = tagq(0, 3'd0, 16'd1, 32'h9000);     // REFE at 0x3F0

    repeat (3) @(negedge clk);
    check("R8 reset ctrl", ctrl, 0);
    check("R8 reset busy/irq/err", {busy, done_irq, bus_err, mv_req, tag_req}, 0);
    rst_n = 1;

    // R1 block mode
    ic = irq_cnt;
    expect_mv("R1", 0, 32'h1000, 16'd3);
    run(32'h100, 32'h1000, 32'h0, 16'd3);
    drained("R1");
    check("R1 madr advanced", madr, 32'h1030);
    check("R1 qwc zero", qwc, 0);
    check("R8 start cleared", ctrl[8], 0);
    check("R8 one done pulse", irq_cnt - ic, 1);

    // R2/R3 CNT then END
    expect_mv("R3 cnt", 0, 32'h10, 16'd2);
    expect_mv("R3 end", 0, 32'h40, 16'd1);
    run(32'h104, 32'h0, 32'h0, 16'd0);
    drained("R3");
    check("R2 ctrl copy", ctrl, 32'h75A5_0004);
    check("R3 end tadr", tadr, 32'h30);
    check("R3 end madr", madr, 32'h50);

    // R6 tag send
    expect_mv("R6 tag0", 1, 32'h0, 16'd1);
    expect_mv("R6 data0", 0, 32'h10, 16'd2);
    expect_mv("R6 tag1", 1, 32'h30, 16'd1);
    expect_mv("R6 data1", 0, 32'h40, 16'd1);
    run(32'h144, 32'h0, 32'h0, 16'd0);
    drained("R6");

    // R4/R5 nested call and return
    expect_mv("R4 call data", 0, 32'h410, 16'd1);
    expect_mv("R5 ret data", 0, 32'h610, 16'd1);
    run(32'h104, 32'h0, 32'h400, 16'd0);
    drained("R5");
    check("R5 final tadr from slot0", tadr, 32'h420);
    check("R5 depth back to 0", ctrl[5:4], 0);
    check("R5 slots cleared", {asr0, asr1}, 0);

    // R4 overflow
    ic = irq_cnt;
    expect_mv("R4 overflow data", 0, 32'h310, 16'd2);
    run(32'h124, 32'h0, 32'h300, 16'd0);
    drained("R4");
    check("R4 overflow tadr kept", tadr, 32'h300);
    check("R4 overflow depth kept", ctrl[5:4], 2);
    check("R4 overflow slots kept", {asr0, asr1}, 0);
    check("R4 overflow ends", irq_cnt - ic, 1);

    // R5 empty and invalid depth
    expect_mv("R5 empty data", 0, 32'h350, 16'd1);
    run(32'h104, 32'h0, 32'h340, 16'd0);
    drained("R5 empty");
    check("R5 empty tadr kept", tadr, 32'h340);
    expect_mv("R5 invalid data", 0, 32'h350, 16'd1);
    run(32'h134, 32'h0, 32'h340, 16'd0);
    drained("R5 invalid");
    check("R5 invalid depth kept", ctrl[5:4], 3);

    // R7 interrupt flag with and without enable
    expect_mv("R7 tie on", 0, 32'h390, 16'd1);
    run(32'h184, 32'h0, 32'h380, 16'd0);
    drained("R7 on");
    check("R7 stopped tadr", tadr, 32'h3A0);
    check("R7 stopped ctrl hi", ctrl[31:16], 16'h95A5);
    expect_mv("R7 tie off", 0, 32'h390, 16'd1);
    run(32'h104, 32'h0, 32'h380, 16'd0);
    drained("R7 off");
    check("R7 continued to END", ctrl[31:16], 16'h75A5);

    // R3 REF / NEXT / REFE
    expect_mv("R3 ref", 0, 32'h8000, 16'd2);
    expect_mv("R3 next", 0, 32'h3E0, 16'd1);
    expect_mv("R3 refe", 0, 32'h9000, 16'd1);
    run(32'h104, 32'h0, 32'h3C0, 16'd0);
    drained("R3 ref");
    check("R3 refe tadr", tadr, 32'h3F0);
    check("R3 refe madr", madr, 32'h9010);

    // R9 bus error
    ic = irq_cnt;
    err_addr = 32'h2C0;
    run(32'h104, 32'h0, 32'h2C0, 16'd0);
    drained("R9");
    check("R9 err flag", bus_err, 1);
    check("R9 start cleared", ctrl[8], 0);
    check("R9 no done", irq_cnt - ic, 0);

    // R10 interleave ignored
    ic = irq_cnt; tc = treq_cnt;
    run(32'h108, 32'h0, 32'h0, 16'd4);
    repeat (20) @(negedge clk);
    drained("R10");
    check("R9 err cleared by write", bus_err, 0);
    check("R10 idle", {busy, mv_req, tag_req}, 0);
    check("R10 no tag read", treq_cnt - tc, 0);
    check("R10 no done", irq_cnt - ic, 0);

    // R11 residual count in chain mode
    ic = irq_cnt; tc = treq_cnt;
    expect_mv("R11", 0, 32'h500, 16'd2);
    run(32'h104, 32'h500, 32'h0, 16'd2);
    drained("R11");
    check("R11 no tag read", treq_cnt - tc, 0);
    check("R11 done", irq_cnt - ic, 1);

    // R12 zero-count tags (0x510 RET, 0x420 END) already produced no move; recheck standalone
    run(32'h104, 32'h0, 32'h3A0, 16'd0);
    drained("R12");
    check("R12 zero count end", {ctrl[8], qwc}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule